// File: doc/BRIEF.md
# Register Rename Stage with Immediate-Add Elimination

This block renames a group of up to five micro-ops per cycle. Each architectural register maps to a pair: a physical register tag and an 11-bit signed displacement. When a micro-op adds or subtracts a constant, the block absorbs it by adjusting the displacement in the map. The micro-op never needs an execution unit, so a chain of dependent constant adds completes with zero latency. Small constant loads are handled the same way: the destination is pointed at the hard-wired zero register (physical tag 0) and the constant goes into the displacement. A recognised zeroing idiom takes a separate path that does not use the per-group elimination budget.

Micro-ops that cannot be absorbed are dispatched with a freshly allocated physical register and a displacement of zero. This covers register-register operations, 32-bit forms, results that overflow the displacement and candidates beyond the budget. Every source operand leaves the stage as a tag plus a displacement, so the consumer adds the displacement to get the true value. Within a group, slots are resolved in program order: a later slot sees the mappings written by earlier valid slots in the same cycle. The whole group stalls if the free list cannot supply every register it needs. Registers return to the free list through a single release port.

Top module: `rename_elim_stage`

## Requirements
- R1: After reset, architectural register i maps to physical tag i+1 with displacement 0. Tags above NUM_AREG are free. Tag 0 is the constant zero register and is never allocated.
- R2: A valid 64-bit (wide_i=1) micro-op of kind 2 (add immediate), 3 (subtract immediate), 4 (increment) or 5 (decrement) can be eliminated. Its delta is imm, -imm, +1 or -1 respectively. When eliminated, the destination maps to the src1 tag with displacement (src1 displacement + delta), and elim_o is 1.
- R3: If the new displacement of an R2 candidate falls outside -1024..+1023, the micro-op is executed instead. Its destination gets a fresh tag and displacement 0.
- R4: Kind 0 (other), kind 1 (register-register add) and R2 kinds with wide_i=0 are never eliminated.
- R5: A valid wide micro-op of kind 6 (move immediate) whose imm lies in -1024..+1023 is eliminated, mapping the destination to tag 0 with displacement imm. Otherwise it is executed.
- R6: Kind 7 (zeroing idiom) is always eliminated, maps the destination to tag 0 with displacement 0, and does not count toward the budget.
- R7: At most MAX_ELIM (4) eliminations under R2 or R5 occur per group, counted in slot order. Later eligible slots are executed.
- R8: A slot's sources and its src1 base see the mappings produced by earlier valid slots of the same group.
- R9: Every slot, valid or not, presents the tag and displacement of its src1 and src2 as seen under R8.
- R10: Executed slots receive the lowest-numbered free tags in slot order, with destination displacement 0.
- R11: If the executed slots of a group need more tags than are free, accept_o is 0 and neither the map nor the free list changes.
- R12: A release of a nonzero tag makes it allocatable from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | GROUP_W | Slot holds a micro-op |
| kind_i | input | GROUP_W*3 | Micro-op kind code per slot |
| wide_i | input | GROUP_W | 64-bit operand size per slot |
| src1_i | input | GROUP_W*AREG_W | First source register |
| src2_i | input | GROUP_W*AREG_W | Second source register |
| dst_i | input | GROUP_W*AREG_W | Destination register |
| imm_i | input | GROUP_W*IMM_W | Signed immediate |
| rel_valid_i | input | 1 | Release a physical tag |
| rel_tag_i | input | TAG_W | Tag being released |
| accept_o | output | 1 | Group renamed and committed this cycle |
| elim_o | output | GROUP_W | Slot absorbed at rename |
| src1_tag_o | output | GROUP_W*TAG_W | First source tag |
| src1_off_o | output | GROUP_W*OFF_W | First source displacement |
| src2_tag_o | output | GROUP_W*TAG_W | Second source tag |
| src2_off_o | output | GROUP_W*OFF_W | Second source displacement |
| dst_tag_o | output | GROUP_W*TAG_W | Destination tag after rename |
| dst_off_o | output | GROUP_W*OFF_W | Destination displacement after rename |

## Verification
The assertions assume two things about the inputs. A tag is released only when it is neither free nor mapped by any architectural register. Register indices stay below NUM_AREG. The bench keeps a reference copy of the map and the free list, and it releases only tags that this copy shows as unreferenced, one per cycle, between groups. Random groups draw indices from the full small register range and draw immediates from a 12-bit span. That span reaches both sides of the displacement boundary without leaving the immediate field.

// File: rtl/rn_pkg.sv
`timescale 1ns/1ps
package rn_pkg;
  typedef enum logic [2:0] {
    K_OTHER = 3'd0,
    K_ADDRR = 3'd1,
    K_ADDI  = 3'd2,
    K_SUBI  = 3'd3,
    K_INC   = 3'd4,
    K_DEC   = 3'd5,
    K_MOVI  = 3'd6,
    K_ZERO  = 3'd7
  } kind_e;
endpackage

// File: rtl/rn_map_table.sv
`timescale 1ns/1ps
module rn_map_table #(
  parameter int NUM_AREG = 16,
  parameter int TAG_W    = 7,
  parameter int OFF_W    = 11
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               load_i,
  input  logic [NUM_AREG-1:0][TAG_W-1:0]     next_tag_i,
  input  logic [NUM_AREG-1:0][OFF_W-1:0]     next_off_i,
  output logic [NUM_AREG-1:0][TAG_W-1:0]     tag_o,
  output logic [NUM_AREG-1:0][OFF_W-1:0]     off_o
);
  logic [NUM_AREG-1:0][TAG_W-1:0] tag_q;
  logic [NUM_AREG-1:0][OFF_W-1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < NUM_AREG; a++) begin
        tag_q[a] <= TAG_W'(a + 1);
        off_q[a] <= '0;
      end
    end else if (load_i) begin
      tag_q <= next_tag_i;
      off_q <= next_off_i;
    end
  end

  assign tag_o = tag_q;
  assign off_o = off_q;
endmodule

// File: rtl/rn_free_list.sv
`timescale 1ns/1ps
module rn_free_list #(
  parameter int NUM_AREG = 16,
  parameter int NUM_PREG = 128,
  parameter int GROUP_W  = 5,
  localparam int TAG_W   = $clog2(NUM_PREG),
  localparam int CNT_W   = $clog2(NUM_PREG + 1),
  localparam int NA_W    = $clog2(GROUP_W + 1)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            alloc_en_i,
  input  logic [NA_W-1:0]                 alloc_num_i,
  input  logic                            rel_valid_i,
  input  logic [TAG_W-1:0]                rel_tag_i,
  output logic [GROUP_W-1:0][TAG_W-1:0]   pick_o,
  output logic [CNT_W-1:0]                free_cnt_o
);
  logic [NUM_PREG-1:0] free_q, free_d;

  // lowest-first picks, one per slot
  always_comb begin
    logic [NUM_PREG-1:0] mask;
    mask = free_q;
    for (int k = 0; k < GROUP_W; k++) begin
      pick_o[k] = '0;
      for (int p = NUM_PREG - 1; p >= 0; p--) begin
        if (mask[p]) pick_o[k] = TAG_W'(p);
      end
      if (mask[pick_o[k]]) mask[pick_o[k]] = 1'b0;
    end
  end

  assign free_cnt_o = CNT_W'($countones(free_q));

  always_comb begin
    free_d = free_q;
    if (alloc_en_i) begin
      for (int k = 0; k < GROUP_W; k++) begin
        if (NA_W'(k) < alloc_num_i) free_d[pick_o[k]] = 1'b0;
      end
    end
    if (rel_valid_i && rel_tag_i != '0) free_d[rel_tag_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_PREG; p++) free_q[p] <= (p > NUM_AREG);
    end else begin
      free_q <= free_d;
    end
  end
endmodule

// File: rtl/rn_group_resolve.sv
`timescale 1ns/1ps
module rn_group_resolve
  import rn_pkg::*;
#(
  parameter int GROUP_W  = 5,
  parameter int MAX_ELIM = 4,
  parameter int NUM_AREG = 16,
  parameter int TAG_W    = 7,
  parameter int OFF_W    = 11,
  parameter int IMM_W    = 16,
  localparam int AREG_W  = $clog2(NUM_AREG),
  localparam int NA_W    = $clog2(GROUP_W + 1),
  localparam int SUM_W   = ((OFF_W > IMM_W) ? OFF_W : IMM_W) + 2
) (
  input  logic [GROUP_W-1:0]                valid_i,
  input  logic [GROUP_W-1:0][2:0]           kind_i,
  input  logic [GROUP_W-1:0]                wide_i,
  input  logic [GROUP_W-1:0][AREG_W-1:0]    src1_i,
  input  logic [GROUP_W-1:0][AREG_W-1:0]    src2_i,
  input  logic [GROUP_W-1:0][AREG_W-1:0]    dst_i,
  input  logic [GROUP_W-1:0][IMM_W-1:0]     imm_i,
  input  logic [NUM_AREG-1:0][TAG_W-1:0]    map_tag_i,
  input  logic [NUM_AREG-1:0][OFF_W-1:0]    map_off_i,
  input  logic [GROUP_W-1:0][TAG_W-1:0]     pick_i,
  output logic [GROUP_W-1:0]                elim_o,
  output logic [GROUP_W-1:0][TAG_W-1:0]     src1_tag_o,
  output logic [GROUP_W-1:0][OFF_W-1:0]     src1_off_o,
  output logic [GROUP_W-1:0][TAG_W-1:0]     src2_tag_o,
  output logic [GROUP_W-1:0][OFF_W-1:0]     src2_off_o,
  output logic [GROUP_W-1:0][TAG_W-1:0]     dst_tag_o,
  output logic [GROUP_W-1:0][OFF_W-1:0]     dst_off_o,
  output logic [NUM_AREG-1:0][TAG_W-1:0]    next_tag_o,
  output logic [NUM_AREG-1:0][OFF_W-1:0]    next_off_o,
  output logic [NA_W-1:0]                   alloc_num_o
);
  localparam logic signed [SUM_W-1:0] OFF_MAX = SUM_W'((1 << (OFF_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] OFF_MIN = -OFF_MAX - SUM_W'(1);

  function automatic logic fits(input logic signed [SUM_W-1:0] v);
    return (v >= OFF_MIN) && (v <= OFF_MAX);
  endfunction

  always_comb begin
    logic [NUM_AREG-1:0][TAG_W-1:0] cur_tag;
    logic [NUM_AREG-1:0][OFF_W-1:0] cur_off;
    logic signed [SUM_W-1:0] base, imm_x, dlt, nw;
    logic [OFF_W-1:0] off1;
    logic cand, add_ok, mov_ok;
    logic [NA_W-1:0] used, na;
    kind_e k;

    cur_tag = map_tag_i;
    cur_off = map_off_i;
    used    = '0;
    na      = '0;
    for (int s = 0; s < GROUP_W; s++) begin
      k = kind_e'(kind_i[s]);
      src1_tag_o[s] = cur_tag[src1_i[s]];
      src1_off_o[s] = cur_off[src1_i[s]];
      src2_tag_o[s] = cur_tag[src2_i[s]];
      src2_off_o[s] = cur_off[src2_i[s]];
      off1  = cur_off[src1_i[s]];
      base  = {{(SUM_W - OFF_W){off1[OFF_W-1]}}, off1};
      imm_x = {{(SUM_W - IMM_W){imm_i[s][IMM_W-1]}}, imm_i[s]};
      unique case (k)
        K_ADDI:  dlt = imm_x;
        K_SUBI:  dlt = -imm_x;
        K_INC:   dlt = SUM_W'(1);
        K_DEC:   dlt = -SUM_W'(1);
        default: dlt = '0;
      endcase
      cand   = wide_i[s] && (k inside {K_ADDI, K_SUBI, K_INC, K_DEC});
      nw     = base + dlt;
      add_ok = cand && fits(nw);
      mov_ok = wide_i[s] && (k == K_MOVI) && fits(imm_x);
      elim_o[s]    = 1'b0;
      dst_tag_o[s] = '0;
      dst_off_o[s] = '0;
      if (valid_i[s]) begin
        if (k == K_ZERO) begin
          elim_o[s] = 1'b1;
        end else if ((add_ok || mov_ok) && (used < NA_W'(MAX_ELIM))) begin
          elim_o[s] = 1'b1;
          used      = used + NA_W'(1);
          if (add_ok) begin
            dst_tag_o[s] = src1_tag_o[s];
            dst_off_o[s] = nw[OFF_W-1:0];
          end else begin
            dst_off_o[s] = imm_x[OFF_W-1:0];
          end
        end else begin
          dst_tag_o[s] = pick_i[na];
          na           = na + NA_W'(1);
        end
        cur_tag[dst_i[s]] = dst_tag_o[s];
        cur_off[dst_i[s]] = dst_off_o[s];
      end
    end
    next_tag_o  = cur_tag;
    next_off_o  = cur_off;
    alloc_num_o = na;
  end
endmodule

// File: rtl/rename_elim_stage.sv
`timescale 1ns/1ps
module rename_elim_stage #(
  parameter int GROUP_W  = 5,
  parameter int MAX_ELIM = 4,
  parameter int NUM_AREG = 16,
  parameter int NUM_PREG = 128,
  parameter int OFF_W    = 11,
  parameter int IMM_W    = 16,
  localparam int AREG_W  = $clog2(NUM_AREG),
  localparam int TAG_W   = $clog2(NUM_PREG)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [GROUP_W-1:0]                valid_i,
  input  logic [GROUP_W-1:0][2:0]           kind_i,
  input  logic [GROUP_W-1:0]                wide_i,
  input  logic [GROUP_W-1:0][AREG_W-1:0]    src1_i,
  input  logic [GROUP_W-1:0][AREG_W-1:0]    src2_i,
  input  logic [GROUP_W-1:0][AREG_W-1:0]    dst_i,
  input  logic [GROUP_W-1:0][IMM_W-1:0]     imm_i,
  input  logic                              rel_valid_i,
  input  logic [TAG_W-1:0]                  rel_tag_i,
  output logic                              accept_o,
  output logic [GROUP_W-1:0]                elim_o,
  output logic [GROUP_W-1:0][TAG_W-1:0]     src1_tag_o,
  output logic [GROUP_W-1:0][OFF_W-1:0]     src1_off_o,
  output logic [GROUP_W-1:0][TAG_W-1:0]     src2_tag_o,
  output logic [GROUP_W-1:0][OFF_W-1:0]     src2_off_o,
  output logic [GROUP_W-1:0][TAG_W-1:0]     dst_tag_o,
  output logic [GROUP_W-1:0][OFF_W-1:0]     dst_off_o
);
  localparam int CNT_W = $clog2(NUM_PREG + 1);
  localparam int NA_W  = $clog2(GROUP_W + 1);

  logic [NUM_AREG-1:0][TAG_W-1:0] map_tag, next_tag;
  logic [NUM_AREG-1:0][OFF_W-1:0] map_off, next_off;
  logic [GROUP_W-1:0][TAG_W-1:0]  pick;
  logic [CNT_W-1:0]               free_cnt;
  logic [NA_W-1:0]                alloc_num;
  logic                           stall;

  assign stall    = CNT_W'(alloc_num) > free_cnt;
  assign accept_o = (|valid_i) && !stall;

  rn_map_table #(
    .NUM_AREG(NUM_AREG), .TAG_W(TAG_W), .OFF_W(OFF_W)
  ) u_map (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(!stall),
    .next_tag_i(next_tag), .next_off_i(next_off),
    .tag_o(map_tag), .off_o(map_off)
  );

  rn_free_list #(
    .NUM_AREG(NUM_AREG), .NUM_PREG(NUM_PREG), .GROUP_W(GROUP_W)
  ) u_free (
    .clk_i(clk_i), .rst_ni(rst_ni), .alloc_en_i(!stall),
    .alloc_num_i(alloc_num), .rel_valid_i(rel_valid_i),
    .rel_tag_i(rel_tag_i), .pick_o(pick), .free_cnt_o(free_cnt)
  );

  rn_group_resolve #(
    .GROUP_W(GROUP_W), .MAX_ELIM(MAX_ELIM), .NUM_AREG(NUM_AREG),
    .TAG_W(TAG_W), .OFF_W(OFF_W), .IMM_W(IMM_W)
  ) u_res (
    .valid_i(valid_i), .kind_i(kind_i), .wide_i(wide_i),
    .src1_i(src1_i), .src2_i(src2_i), .dst_i(dst_i), .imm_i(imm_i),
    .map_tag_i(map_tag), .map_off_i(map_off), .pick_i(pick),
    .elim_o(elim_o),
    .src1_tag_o(src1_tag_o), .src1_off_o(src1_off_o),
    .src2_tag_o(src2_tag_o), .src2_off_o(src2_off_o),
    .dst_tag_o(dst_tag_o), .dst_off_o(dst_off_o),
    .next_tag_o(next_tag), .next_off_o(next_off),
    .alloc_num_o(alloc_num)
  );
endmodule

// File: rtl/rn_checker.sv
`timescale 1ns/1ps
module rn_checker #(
  parameter int GROUP_W  = 5,
  parameter int MAX_ELIM = 4,
  parameter int NUM_AREG = 16,
  parameter int TAG_W    = 7,
  parameter int OFF_W    = 11
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [GROUP_W-1:0]              valid_i,
  input logic [GROUP_W-1:0][2:0]         kind_i,
  input logic [GROUP_W-1:0]              wide_i,
  input logic                            accept_o,
  input logic [GROUP_W-1:0]              elim_o,
  input logic [GROUP_W-1:0][TAG_W-1:0]   dst_tag_o,
  input logic [GROUP_W-1:0][OFF_W-1:0]   dst_off_o,
  input logic [NUM_AREG-1:0][TAG_W-1:0]  map_tag,
  input logic [NUM_AREG-1:0][OFF_W-1:0]  map_off
);
  logic [GROUP_W-1:0] zero_slot;
  always_comb begin
    for (int s = 0; s < GROUP_W; s++) zero_slot[s] = valid_i[s] && (kind_i[s] == 3'd7);
  end

  p_budget_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> ($countones(elim_o & ~zero_slot) <= MAX_ELIM));

  p_stall_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|valid_i) && !accept_o) |=> ($stable(map_tag) && $stable(map_off)));

  for (genvar s = 0; s < GROUP_W; s++) begin : g_slot
    p_zero_idiom_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i[s] && kind_i[s] == 3'd7) |-> (elim_o[s] && dst_tag_o[s] == '0 && dst_off_o[s] == '0));
    p_regreg_exec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i[s] && kind_i[s] <= 3'd1) |-> !elim_o[s]);
    p_narrow_exec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i[s] && !wide_i[s] && kind_i[s] >= 3'd2 && kind_i[s] <= 3'd6) |-> !elim_o[s]);
    p_exec_fresh_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept_o && valid_i[s] && !elim_o[s]) |-> (dst_off_o[s] == '0 && dst_tag_o[s] != '0));
    p_invalid_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i[s] |-> !elim_o[s]);
  end
endmodule

bind rename_elim_stage rn_checker #(
  .GROUP_W(GROUP_W), .MAX_ELIM(MAX_ELIM), .NUM_AREG(NUM_AREG),
  .TAG_W(TAG_W), .OFF_W(OFF_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .kind_i(kind_i),
  .wide_i(wide_i), .accept_o(accept_o), .elim_o(elim_o),
  .dst_tag_o(dst_tag_o), .dst_off_o(dst_off_o),
  .map_tag(map_tag), .map_off(map_off)
);

// File: tb/tb_rename_elim_stage.sv
`timescale 1ns/1ps
module tb_rename_elim_stage;
  localparam int G  = 5;
  localparam int ME = 4;
  localparam int NA = 4;
  localparam int NP = 16;
  localparam int OW = 11;
  localparam int IW = 12;
  localparam int AW = 2;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [G-1:0]          valid_i = '0;
  logic [G-1:0][2:0]     kind_i = '0;
  logic [G-1:0]          wide_i = '0;
  logic [G-1:0][AW-1:0]  src1_i = '0, src2_i = '0, dst_i = '0;
  logic [G-1:0][IW-1:0]  imm_i = '0;
  logic                  rel_valid_i = 1'b0;
  logic [TW-1:0]         rel_tag_i = '0;
  logic                  accept_o;
  logic [G-1:0]          elim_o;
  logic [G-1:0][TW-1:0]  src1_tag_o, src2_tag_o, dst_tag_o;
  logic [G-1:0][OW-1:0]  src1_off_o, src2_off_o, dst_off_o;

  rename_elim_stage #(
    .GROUP_W(G), .MAX_ELIM(ME), .NUM_AREG(NA), .NUM_PREG(NP), .OFF_W(OW), .IMM_W(IW)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .kind_i(kind_i), .wide_i(wide_i),
    .src1_i(src1_i), .src2_i(src2_i), .dst_i(dst_i), .imm_i(imm_i),
    .rel_valid_i(rel_valid_i), .rel_tag_i(rel_tag_i), .accept_o(accept_o),
    .elim_o(elim_o), .src1_tag_o(src1_tag_o), .src1_off_o(src1_off_o),
    .src2_tag_o(src2_tag_o), .src2_off_o(src2_off_o),
    .dst_tag_o(dst_tag_o), .dst_off_o(dst_off_o)
  );

  int rtag[NA];
  int roff[NA];
  bit rfree[NP];
  int g_valid[G], g_kind[G], g_wide[G], g_s1[G], g_s2[G], g_d[G], g_imm[G];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit fits(input int v);
    return (v >= -(1 << (OW - 1))) && (v <= (1 << (OW - 1)) - 1);
  endfunction

  task automatic clear_group();
    for (int s = 0; s < G; s++) begin
      g_valid[s] = 0; g_kind[s] = 0; g_wide[s] = 1;
      g_s1[s] = s % NA; g_s2[s] = (s + 1) % NA; g_d[s] = s % NA; g_imm[s] = 0;
    end
  endtask

  task automatic set_slot(input int s, input int k, input int w, input int d, input int s1, input int im);
    g_valid[s] = 1; g_kind[s] = k; g_wide[s] = w; g_d[s] = d; g_s1[s] = s1; g_imm[s] = im;
  endtask

  task automatic apply_group(input string ctx);
    int ct[NA];
    int co[NA];
    int e1t[G], e1o[G], e2t[G], e2o[G], edt[G], edo[G];
    bit eel[G];
    int picks[G];
    int used, na, fc, dl, nw;
    bit anyv, stall, cand;
    @(negedge clk);
    for (int s = 0; s < G; s++) begin
      valid_i[s] = (g_valid[s] != 0);
      kind_i[s]  = 3'(g_kind[s]);
      wide_i[s]  = (g_wide[s] != 0);
      src1_i[s]  = AW'(g_s1[s]);
      src2_i[s]  = AW'(g_s2[s]);
      dst_i[s]   = AW'(g_d[s]);
      imm_i[s]   = IW'(g_imm[s]);
    end
    fc = 0;
    for (int p = 1; p < NP; p++) begin
      if (rfree[p]) begin
        if (fc < G) picks[fc] = p;
        fc++;
      end
    end
    ct = rtag; co = roff; used = 0; na = 0; anyv = 0;
    for (int s = 0; s < G; s++) begin
      e1t[s] = ct[g_s1[s]]; e1o[s] = co[g_s1[s]];
      e2t[s] = ct[g_s2[s]]; e2o[s] = co[g_s2[s]];
      eel[s] = 0; edt[s] = 0; edo[s] = 0;
      if (g_valid[s] != 0) begin
        anyv = 1;
        case (g_kind[s])
          2: dl = g_imm[s];
          3: dl = -g_imm[s];
          4: dl = 1;
          5: dl = -1;
          default: dl = 0;
        endcase
        cand = (g_wide[s] != 0) && g_kind[s] >= 2 && g_kind[s] <= 5;
        nw = e1o[s] + dl;
        if (g_kind[s] == 7) begin
          eel[s] = 1;
        end else if (((cand && fits(nw)) || (g_kind[s] == 6 && g_wide[s] != 0 && fits(g_imm[s]))) && used < ME) begin
          eel[s] = 1; used++;
          if (cand) begin edt[s] = e1t[s]; edo[s] = nw; end
          else edo[s] = g_imm[s];
        end else begin
          edt[s] = (na < fc) ? picks[na] : -1;
          na++;
        end
        ct[g_d[s]] = edt[s]; co[g_d[s]] = edo[s];
      end
    end
    stall = na > fc;
    #5;
    chk({ctx, " accept"}, int'(accept_o), int'(anyv && !stall));
    for (int s = 0; s < G; s++) begin
      if (e1t[s] >= 0) chk({ctx, " src1 tag"}, int'(src1_tag_o[s]), e1t[s]);
      if (e1t[s] >= 0) chk({ctx, " src1 off"}, int'($signed(src1_off_o[s])), e1o[s]);
      if (e2t[s] >= 0) chk({ctx, " src2 tag"}, int'(src2_tag_o[s]), e2t[s]);
      if (e2t[s] >= 0) chk({ctx, " src2 off"}, int'($signed(src2_off_o[s])), e2o[s]);
      chk({ctx, " elim"}, int'(elim_o[s]), int'(eel[s]));
      if (g_valid[s] != 0 && edt[s] >= 0 && (!stall || eel[s])) begin
        chk({ctx, " dst tag"}, int'(dst_tag_o[s]), edt[s]);
        chk({ctx, " dst off"}, int'($signed(dst_off_o[s])), edo[s]);
      end
    end
    if (anyv && !stall) begin
      rtag = ct; roff = co;
      for (int k = 0; k < na; k++) rfree[picks[k]] = 0;
    end
  endtask

  task automatic probe(input string ctx);
    clear_group();
    apply_group(ctx);
  endtask

  task automatic cleanup();
    bit mapped;
    for (int p = 1; p < NP; p++) begin
      mapped = 0;
      for (int a = 0; a < NA; a++) if (rtag[a] == p) mapped = 1;
      if (!rfree[p] && !mapped) begin
        @(negedge clk);
        valid_i = '0;
        rel_valid_i = 1'b1; rel_tag_i = TW'(p);
        rfree[p] = 1;
        @(negedge clk);
        rel_valid_i = 1'b0;
      end
    end
  endtask

  task automatic rand_group();
    int r;
    clear_group();
    for (int s = 0; s < G; s++) begin
      g_valid[s] = ($urandom_range(0, 5) != 0);
      r = $urandom_range(0, 9);
      case (r)
        0: g_kind[s] = 0; 1: g_kind[s] = 1; 2, 9: g_kind[s] = 2; 3: g_kind[s] = 3;
        4: g_kind[s] = 4; 5: g_kind[s] = 5; 6: g_kind[s] = 6; default: g_kind[s] = 7;
      endcase
      g_wide[s] = ($urandom_range(0, 7) != 0);
      g_d[s]  = $urandom_range(0, NA - 1);
      g_s1[s] = ($urandom_range(0, 3) != 0) ? g_d[s] : $urandom_range(0, NA - 1);
      g_s2[s] = $urandom_range(0, NA - 1);
      case ($urandom_range(0, 3))
        0: g_imm[s] = $urandom_range(0, 16) - 8;
        1: g_imm[s] = $urandom_range(0, 600) - 300;
        2: g_imm[s] = $urandom_range(0, 4095) - 2048;
        default: g_imm[s] = ($urandom_range(0, 1) != 0) ? 1023 : -1024;
      endcase
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < NA; a++) begin rtag[a] = a + 1; roff[a] = 0; end
    for (int p = 0; p < NP; p++) rfree[p] = (p > NA);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    probe("R1_R9 reset map");

    clear_group();
    for (int s = 0; s < G; s++) set_slot(s, 0, 1, s % NA, s % NA, 0);
    apply_group("R10 lowest-first alloc");
    probe("R8_R9"); cleanup();

    clear_group();
    for (int s = 0; s < G; s++) set_slot(s, 2, 1, 1, 1, 256);
    apply_group("R2_R3 add chain overflow");
    probe("R9"); cleanup();

    clear_group();
    for (int s = 0; s < G; s++) set_slot(s, 4, 1, s % NA, s % NA, 0);
    apply_group("R7 budget");
    probe("R9"); cleanup();

    clear_group();
    set_slot(0, 7, 1, 2, 2, 0);
    for (int s = 1; s < G; s++) set_slot(s, 4, 1, s - 1, s - 1, 0);
    apply_group("R6 zero idiom free of budget");
    probe("R9"); cleanup();

    clear_group();
    set_slot(0, 6, 1, 2, 0, -1000);
    set_slot(1, 3, 1, 2, 2, 24);
    set_slot(2, 5, 1, 2, 2, 0);
    set_slot(3, 2, 1, 2, 2, 5);
    set_slot(4, 4, 1, 3, 2, 0);
    apply_group("R5_R3 lower bound");
    probe("R9"); cleanup();

    clear_group();
    set_slot(0, 2, 0, 0, 0, 3);
    set_slot(1, 1, 1, 1, 0, 0);
    set_slot(2, 6, 1, 2, 0, 1500);
    set_slot(3, 6, 0, 3, 0, 7);
    set_slot(4, 2, 1, 0, 0, 1023);
    apply_group("R4_R5 not eligible");
    probe("R9"); cleanup();

    for (int i = 0; i < 3; i++) begin
      clear_group();
      for (int s = 0; s < G; s++) set_slot(s, 1, 1, s % NA, (s + 1) % NA, 0);
      apply_group("R11 stall");
      probe("R11 map held");
    end
    cleanup();
    clear_group();
    for (int s = 0; s < G; s++) set_slot(s, 0, 1, s % NA, s % NA, 0);
    apply_group("R12 released regs reused");
    probe("R12"); cleanup();

    for (int i = 0; i < 800; i++) begin
      rand_group();
      apply_group("R8 random");
      probe("R9");
      if (i % 5 != 0) cleanup();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule